// File: doc/BRIEF.md
# Overlapping 1-0-1 Serial Pattern Detector

This block watches a serial stream, one bit per accepted clock cycle, and raises a flag in the very cycle that the closing 1 of the pattern 1-0-1 is presented. The flag is a Mealy output. It is formed from the stored progress through the pattern together with the bit on the input in that cycle, so it needs no extra register stage. Matches may overlap: the final 1 of one match also serves as the leading 1 of the next, so the stream 1,0,1,0,1 gives two hits.

The progress is held in a three-state machine. The first state waits for a leading 1, the second waits for a 0, and the third waits for the closing 1. A valid strobe qualifies each bit. On cycles where the strobe is low, the stored progress is frozen and the flag stays low. A synchronous reset returns the machine to its idle state. The unused two-bit code always recovers to idle on the next clock, so a corrupted state cannot hang the machine.

Top module: `seq101_det`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to idle and `hit` is low. After reset, only accepted bits count toward a match, so a full 1,0,1 is needed before the first hit.
- R2: `hit` is 1 in the same cycle that `bit_vld`=1 and `bit_in`=1 are presented, provided the two previously accepted bits were 1 then 0. In every other cycle `hit` is 0.
- R3: Matches overlap. After a hit, the machine is waiting for a 0, so the accepted stream 1,0,1,0,1 produces hits on the third and fifth bits.
- R4: A cycle with `bit_vld`=0 has no effect: `hit` is 0 in that cycle, and the stored progress is unchanged. A pattern split by invalid cycles is still detected.
- R5: A run of 1s keeps the machine waiting for a 0, so the stream 1,1,0,1 gives a hit on the fourth bit.
- R6: A second 0 in a row abandons the partial match, so the stream 1,0,0,1 gives no hit. A later 0,1 does not complete the pattern without a new leading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Combinational match flag, high on the closing 1 |

## Verification
The bench applies every 8-bit stream from reset and also runs a long random stream with random gaps in the strobe. In each case it compares `hit` against the last three accepted bits, tracked in a shift register of its own. These runs catch several classes of error:
- A design that returns to idle after a match misses the second hit of 1,0,1,0,1.
- One that leaves the second state on a repeated 1 misses 1,1,0,1.
- One that stays in the third state on a 0 reports a false hit on 1,0,0,1.

Streams broken by low-strobe cycles expose two further faults: a machine that advances on unqualified bits, and a flag that is not gated by the strobe. Holding reset high with a 1 on the input checks that reset masks the flag.

// File: rtl/seq101_pkg.sv
package seq101_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 2'b00,  // waiting for a leading 1
    ST_ONE  = 2'b01,  // saw 1, waiting for 0
    ST_ZERO = 2'b10,  // saw 1,0, waiting for closing 1
    ST_BAD  = 2'b11   // unused code
  } det_state_e;

  // Step of the pattern machine for one accepted bit.
  function automatic det_state_e step_state(det_state_e cur, logic b);
    det_state_e nxt;
    case (cur)
      ST_IDLE: nxt = b ? ST_ONE : ST_IDLE;
      ST_ONE:  nxt = b ? ST_ONE : ST_ZERO;
      ST_ZERO: nxt = b ? ST_ONE : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Mealy match term for one accepted bit.
  function automatic logic match_term(det_state_e cur, logic b);
    return (cur == ST_ZERO) && b;
  endfunction

endpackage

// File: rtl/seq101_next.sv
module seq101_next
  import seq101_pkg::*;
(
  input  det_state_e cur_st,
  input  logic       vld,
  input  logic       din,
  output det_state_e nxt_st
);
  always_comb begin
    if (vld) nxt_st = step_state(cur_st, din);
    else     nxt_st = (cur_st == ST_BAD) ? ST_IDLE : cur_st;
  end
endmodule

// File: rtl/seq101_streg.sv
module seq101_streg
  import seq101_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  det_state_e d,
  output det_state_e q
);
  always_ff @(posedge clk) begin
    if (rst) q <= ST_IDLE;
    else     q <= d;
  end
endmodule

// File: rtl/seq101_out.sv
module seq101_out
  import seq101_pkg::*;
(
  input  det_state_e cur_st,
  input  logic       rst,
  input  logic       vld,
  input  logic       din,
  output logic       match
);
  always_comb match = vld && !rst && match_term(cur_st, din);
endmodule

// File: rtl/seq101_det.sv
module seq101_det
  import seq101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);
  det_state_e state_q;
  det_state_e state_d;
  logic       match_w;

  seq101_next u_next (
    .cur_st (state_q),
    .vld    (bit_vld),
    .din    (bit_in),
    .nxt_st (state_d)
  );

  seq101_streg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  seq101_out u_out (
    .cur_st (state_q),
    .rst    (rst),
    .vld    (bit_vld),
    .din    (bit_in),
    .match  (match_w)
  );

  assign hit = match_w;
endmodule

// File: rtl/seq101_det_chk.sv
module seq101_det_chk
  import seq101_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_vld,
  input logic       bit_in,
  input logic       hit,
  input det_state_e state_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> state_q == ST_IDLE);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |-> !hit);
  // R2
  hit_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (state_q == ST_ZERO) && bit_vld && bit_in);
  // R3
  hit_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> state_q == ST_ONE);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && state_q != ST_BAD) |=> $stable(state_q));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !hit);
  // R5
  ones_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONE && bit_vld && bit_in) |=> state_q == ST_ONE);
  // R6
  double_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ZERO && bit_vld && !bit_in) |=> state_q == ST_IDLE);
endmodule

bind seq101_det seq101_det_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_vld (bit_vld),
  .bit_in  (bit_in),
  .hit     (hit),
  .state_q (state_q)
);

// File: tb/seq101_det_tb.sv
`timescale 1ns/1ps
module seq101_det_tb;
  logic clk = 1'b0;
  logic rst, bit_vld, bit_in;
  logic hit;
  int   checks = 0;
  int   errors = 0;
  logic [2:0] hist;
  int   acc;
  int   hits_seen;

  always #5 clk = ~clk;

  seq101_det u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .hit(hit)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // R1: reset with a 1 presented, hit must stay low
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    #2 chk(hit, 1'b0, "R1 reset masks hit");
    @(negedge clk);
    rst = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    hist = 3'b000; acc = 0;
  endtask

  // Drive one cycle; expected hit from reference history of accepted bits
  task automatic drive(input logic v, input logic b, input string req);
    logic exp;
    bit_vld = v; bit_in = b;
    exp = v && b && (acc >= 2) && (hist[1:0] == 2'b10);
    #2 chk(hit, exp, req);
    if (exp) hits_seen++;
    @(negedge clk);
    if (v) begin
      hist = {hist[1:0], b};
      acc++;
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
    hist = 3'b000; acc = 0; hits_seen = 0;
    repeat (2) @(negedge clk);
    do_reset();

    // R3: overlapping 10101 gives two hits
    hits_seen = 0;
    drive(1,1,"R3"); drive(1,0,"R3"); drive(1,1,"R3 first hit");
    drive(1,0,"R3"); drive(1,1,"R3 second hit");
    checks++;
    if (hits_seen != 2) begin
      errors++;
      $display("FAIL R3: hits=%0d expected 2", hits_seen);
    end

    // R5: 1101
    do_reset();
    drive(1,1,"R5"); drive(1,1,"R5"); drive(1,0,"R5"); drive(1,1,"R5 hit");

    // R6: 1001 then 01 without new leading 1
    do_reset();
    drive(1,1,"R6"); drive(1,0,"R6"); drive(1,0,"R6");
    drive(1,1,"R6 no hit"); drive(1,1,"R6");

    // R4: pattern split by invalid cycles, invalid 1 in the gap
    do_reset();
    drive(1,1,"R4"); drive(0,0,"R4 gap"); drive(1,0,"R4");
    drive(0,1,"R4 gated 1"); drive(0,0,"R4 gap"); drive(1,1,"R4 split hit");

    // R1: bits before reset are forgotten
    drive(1,0,"R1");
    do_reset();
    drive(1,1,"R1 after reset"); drive(1,1,"R1 after reset");

    // R2: exhaustive 8-bit streams from reset
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int i = 7; i >= 0; i--) drive(1, p[i], "R2 sweep");
    end

    // R2/R4: random stream with random strobe gaps
    do_reset();
    for (int n = 0; n < 20000; n++) begin
      drive(($urandom % 4) != 0, $urandom % 2, "R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule